// File: doc/BRIEF.md
# Bit-Serial CRC Engine

The block computes a cyclic redundancy check over a stream of bytes, advancing its check register by one message bit per clock. A byte therefore occupies the engine for eight cycles. Register width, generator polynomial, initial value, output XOR mask, shift direction and an optional reversal of the result bits are all fixed by parameters. The same datapath serves both the right-shifting, least-significant-bit-first form (polynomial written in reflected order) and the left-shifting, most-significant-bit-first form (polynomial written in normal order).

A message opens with a one-cycle `start_i` pulse. Bytes enter through a valid/ready handshake; the byte flagged with `in_last_i` closes the message. A message may also be closed without a byte by a `close_i` pulse, which makes empty messages possible. When the message closes, the output XOR and optional bit reversal are applied combinationally. The formatted check value appears on `crc_o` together with a one-cycle `done_o` strobe. It then stays unchanged until the next start.

The controller has five states. ST_IDLE is entered from reset and no message is open. ST_ACCEPT has ready high and waits for a byte or a close. ST_SHIFT runs eight single-bit updates. ST_FINISH raises the done strobe. ST_HOLD freezes the result. Transitions: ACCEPT→SHIFT on an accepted byte; ACCEPT→FINISH on close; SHIFT→ACCEPT after the eighth bit of a non-final byte; SHIFT→FINISH after the eighth bit of the final byte; FINISH→HOLD unconditionally. A start pulse moves any state to ACCEPT.

Top module: `crc_serial_engine`

## Requirements
- R1: After reset `done_o` and `in_ready_o` are both 0.
- R2: A `start_i` pulse loads the initial value and aborts any message in progress. On the following cycle `in_ready_o` is 1 and `done_o` is 0.
- R3: A byte is accepted on a clock edge where `in_valid_i` and `in_ready_o` are both 1 and `start_i` is 0. `in_ready_o` is then 0 for exactly 8 cycles. It returns to 1 afterwards unless that byte was flagged last.
- R4: With REFLECT=1, the bits of each byte are consumed in order from bit 0 to bit 7. Each step shifts the register right by one place. If the old register bit 0 differed from the data bit, the polynomial is then XORed in.
- R5: With REFLECT=0, the bits of each byte are consumed in order from bit 7 to bit 0. Each step shifts the register left by one place. If the old register top bit differed from the data bit, the polynomial is then XORed in.
- R6: `crc_o` equals the register XORed with the XOR_OUT parameter.
- R7: With REV_OUT=1, after the XOR, bit j of the result is moved to bit WIDTH-1-j.
- R8: `done_o` goes to 1 for exactly one cycle, at the 8th edge after the final byte is accepted. A close pulse instead raises `done_o` for one cycle on the next edge.
- R9: After `done_o`, `crc_o` holds its value and `in_ready_o` stays 0 until the next `start_i`. Any `in_valid_i` activity in that time has no effect.
- R10: Closing a message that holds no bytes yields the initial value with the output XOR and reversal applied.
- R11: With the 32-bit reflected setup (polynomial EDB88320h, initial value all ones, output XOR all ones), the ASCII string "123456789" gives CBF43926h. The 8-bit normal setup (polynomial 07h, initial value 0, no output XOR) gives F4h for the same string.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Opens a new message and loads the initial value |
| in_valid_i | input | 1 | Byte on `in_data_i` is offered |
| in_data_i | input | 8 | Message byte |
| in_last_i | input | 1 | Offered byte is the final one of the message |
| close_i | input | 1 | Close the message without a byte (used when `in_valid_i` is 0) |
| in_ready_o | output | 1 | Engine can take a byte |
| crc_o | output | WIDTH | Formatted check value |
| done_o | output | 1 | One-cycle strobe when the result becomes valid |

## Verification
Three instances run the same stimulus: the reflected 32-bit setup, a normal 8-bit setup, and a normal 8-bit setup with a nonzero output mask and bit reversal. Their results are compared against a bench model across random message lengths and contents.
- A swapped bit order or shift direction yields wrong results on all random messages and on the "123456789" check values.
- A dropped output mask or reversal shows up only on the instances that use it.
- An off-by-one bit counter shortens or stretches the eight-cycle ready gap, and the per-cycle sampling of ready and done catches it.
- Empty messages and a start pulse in the middle of a byte expose a design that skips the initial load or lets the aborted byte leak into the new message.
- Bytes offered after completion catch a result that is not frozen.

// File: rtl/crc_serial_pkg.sv
package crc_serial_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACCEPT,
        ST_SHIFT,
        ST_FINISH,
        ST_HOLD
    } crc_state_e;

    localparam int BYTE_BITS = 8;
    localparam int IDX_W     = $clog2(BYTE_BITS);

endpackage

// File: rtl/crc_seq_ctrl.sv
module crc_seq_ctrl
    import crc_serial_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             in_valid_i,
    input  logic             in_last_i,
    input  logic             close_i,
    output logic             load_init_o,
    output logic             take_byte_o,
    output logic             shift_en_o,
    output logic [IDX_W-1:0] bit_idx_o,
    output logic             ready_o,
    output logic             done_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_BITS - 1);

    crc_state_e       st_q, st_d;
    logic [IDX_W-1:0] idx_q;
    logic             last_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d = ST_ACCEPT;
        end else begin
            unique case (st_q)
                ST_IDLE:   st_d = ST_IDLE;
                ST_ACCEPT: begin
                    if (in_valid_i) begin
                        st_d = ST_SHIFT;
                    end else if (close_i) begin
                        st_d = ST_FINISH;
                    end
                end
                ST_SHIFT: begin
                    if (idx_q == LAST_IDX) begin
                        st_d = last_q ? ST_FINISH : ST_ACCEPT;
                    end
                end
                ST_FINISH: st_d = ST_HOLD;
                ST_HOLD:   st_d = ST_HOLD;
                default:   st_d = ST_IDLE;
            endcase
        end
    end

    // bit position and final-byte flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            last_q <= 1'b0;
        end else if (start_i) begin
            idx_q  <= '0;
            last_q <= 1'b0;
        end else if (take_byte_o) begin
            idx_q  <= '0;
            last_q <= in_last_i;
        end else if (shift_en_o) begin
            idx_q  <= idx_q + 1'b1;
        end
    end

    // outputs decoded from state
    always_comb begin
        ready_o     = 1'b0;
        done_o      = 1'b0;
        shift_en_o  = 1'b0;
        unique case (st_q)
            ST_IDLE:   ;
            ST_ACCEPT: ready_o = 1'b1;
            ST_SHIFT:  shift_en_o = !start_i;
            ST_FINISH: done_o = 1'b1;
            ST_HOLD:   ;
            default:   ;
        endcase
        load_init_o = start_i;
        take_byte_o = ready_o && in_valid_i && !start_i;
    end

    assign bit_idx_o = idx_q;

endmodule

// File: rtl/crc_shift_path.sv
module crc_shift_path
    import crc_serial_pkg::*;
#(
    parameter int               WIDTH   = 32,
    parameter logic [WIDTH-1:0] POLY    = 32'hEDB88320,
    parameter logic [WIDTH-1:0] INIT    = '1,
    parameter bit               REFLECT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_init_i,
    input  logic             take_byte_i,
    input  logic [7:0]       byte_i,
    input  logic             shift_en_i,
    input  logic [IDX_W-1:0] bit_idx_i,
    output logic [WIDTH-1:0] crc_o
);

    logic [WIDTH-1:0] crc_q, crc_step;
    logic [7:0]       byte_q;
    logic             data_bit, feedback;

    generate
        if (REFLECT) begin : g_reflected
            always_comb begin
                data_bit = byte_q[bit_idx_i];
                feedback = crc_q[0] ^ data_bit;
                crc_step = (crc_q >> 1) ^ (feedback ? POLY : '0);
            end
        end else begin : g_normal
            always_comb begin
                data_bit = byte_q[IDX_W'(BYTE_BITS - 1) - bit_idx_i];
                feedback = crc_q[WIDTH-1] ^ data_bit;
                crc_step = (crc_q << 1) ^ (feedback ? POLY : '0);
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q  <= INIT;
            byte_q <= '0;
        end else begin
            if (load_init_i) begin
                crc_q <= INIT;
            end else if (shift_en_i) begin
                crc_q <= crc_step;
            end
            if (take_byte_i) begin
                byte_q <= byte_i;
            end
        end
    end

    assign crc_o = crc_q;

endmodule

// File: rtl/crc_result_fmt.sv
module crc_result_fmt #(
    parameter int               WIDTH   = 32,
    parameter logic [WIDTH-1:0] XOR_OUT = '1,
    parameter bit               REV_OUT = 1'b0
) (
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] fmt_o
);

    logic [WIDTH-1:0] masked;

    assign masked = raw_i ^ XOR_OUT;

    generate
        if (REV_OUT) begin : g_rev
            for (genvar j = 0; j < WIDTH; j++) begin : g_bit
                assign fmt_o[WIDTH-1-j] = masked[j];
            end
        end else begin : g_pass
            assign fmt_o = masked;
        end
    endgenerate

endmodule

// File: rtl/crc_serial_engine.sv
module crc_serial_engine
    import crc_serial_pkg::*;
#(
    parameter int               WIDTH   = 32,
    parameter logic [WIDTH-1:0] POLY    = 32'hEDB88320,
    parameter logic [WIDTH-1:0] INIT    = '1,
    parameter logic [WIDTH-1:0] XOR_OUT = '1,
    parameter bit               REFLECT = 1'b1,
    parameter bit               REV_OUT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             in_valid_i,
    input  logic [7:0]       in_data_i,
    input  logic             in_last_i,
    input  logic             close_i,
    output logic             in_ready_o,
    output logic [WIDTH-1:0] crc_o,
    output logic             done_o
);

    logic             load_init, take_byte, shift_en;
    logic [IDX_W-1:0] bit_idx;
    logic [WIDTH-1:0] crc_raw;

    crc_seq_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .in_valid_i  (in_valid_i),
        .in_last_i   (in_last_i),
        .close_i     (close_i),
        .load_init_o (load_init),
        .take_byte_o (take_byte),
        .shift_en_o  (shift_en),
        .bit_idx_o   (bit_idx),
        .ready_o     (in_ready_o),
        .done_o      (done_o)
    );

    crc_shift_path #(
        .WIDTH   (WIDTH),
        .POLY    (POLY),
        .INIT    (INIT),
        .REFLECT (REFLECT)
    ) u_path (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_init_i (load_init),
        .take_byte_i (take_byte),
        .byte_i      (in_data_i),
        .shift_en_i  (shift_en),
        .bit_idx_i   (bit_idx),
        .crc_o       (crc_raw)
    );

    crc_result_fmt #(
        .WIDTH   (WIDTH),
        .XOR_OUT (XOR_OUT),
        .REV_OUT (REV_OUT)
    ) u_fmt (
        .raw_i (crc_raw),
        .fmt_o (crc_o)
    );

endmodule

// File: rtl/crc_serial_engine_chk.sv
module crc_serial_engine_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             in_valid_i,
    input logic             close_i,
    input logic             in_ready_o,
    input logic             done_o,
    input logic [WIDTH-1:0] crc_o
);

    logic [3:0] busy_cnt;
    logic       held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
            held     <= 1'b0;
        end else begin
            if (start_i) begin
                busy_cnt <= '0;
            end else if (in_valid_i && in_ready_o) begin
                busy_cnt <= 4'd8;
            end else if (busy_cnt != 0) begin
                busy_cnt <= busy_cnt - 1'b1;
            end
            if (start_i) begin
                held <= 1'b0;
            end else if (done_o) begin
                held <= 1'b1;
            end
        end
    end

    p_start_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (in_ready_o && !done_o));

    p_busy_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_cnt != 0) |-> !in_ready_o);

    p_accept_drops_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o && !start_i) |=> (!in_ready_o && !done_o));

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_close_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (close_i && !in_valid_i && in_ready_o && !start_i) |=> done_o);

    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((held || done_o) && !start_i) |=> ($stable(crc_o) && !in_ready_o));

    p_ready_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready_o && done_o));

endmodule

bind crc_serial_engine crc_serial_engine_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .in_valid_i (in_valid_i),
    .close_i    (close_i),
    .in_ready_o (in_ready_o),
    .done_o     (done_o),
    .crc_o      (crc_o)
);

// File: tb/crc_serial_engine_test.sv
module crc_serial_engine_test;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, in_valid_i = 1'b0, in_last_i = 1'b0, close_i = 1'b0;
    logic [7:0]  in_data_i = '0;
    logic        rdy32, rdy8, rdyrv, dn32, dn8, dnrv;
    logic [31:0] crc32;
    logic [7:0]  crc8, crcrv;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] msg [0:63];

    always #(CLK_PERIOD/2) clk = ~clk;

    crc_serial_engine #(.WIDTH(32), .POLY(32'hEDB88320), .INIT(32'hFFFFFFFF),
        .XOR_OUT(32'hFFFFFFFF), .REFLECT(1'b1), .REV_OUT(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .in_valid_i(in_valid_i),
        .in_data_i(in_data_i), .in_last_i(in_last_i), .close_i(close_i),
        .in_ready_o(rdy32), .crc_o(crc32), .done_o(dn32));

    crc_serial_engine #(.WIDTH(8), .POLY(8'h07), .INIT(8'h00),
        .XOR_OUT(8'h00), .REFLECT(1'b0), .REV_OUT(1'b0)) uut_c8 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .in_valid_i(in_valid_i),
        .in_data_i(in_data_i), .in_last_i(in_last_i), .close_i(close_i),
        .in_ready_o(rdy8), .crc_o(crc8), .done_o(dn8));

    crc_serial_engine #(.WIDTH(8), .POLY(8'h07), .INIT(8'hFF),
        .XOR_OUT(8'h0F), .REFLECT(1'b0), .REV_OUT(1'b1)) uut_rv (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .in_valid_i(in_valid_i),
        .in_data_i(in_data_i), .in_last_i(in_last_i), .close_i(close_i),
        .in_ready_o(rdyrv), .crc_o(crcrv), .done_o(dnrv));

    function automatic logic [31:0] ref_crc(input int w, input logic [31:0] poly,
            input logic [31:0] init, input logic [31:0] xo, input bit refl,
            input bit rev, input int n);
        logic [31:0] mask = (w == 32) ? 32'hFFFFFFFF : ((32'd1 << w) - 1);
        logic [31:0] c = init & mask;
        logic [31:0] r = '0;
        for (int i = 0; i < n; i++) begin
            for (int j = 0; j < 8; j++) begin
                logic fb;
                if (refl) begin
                    fb = c[0] ^ msg[i][j];
                    c  = c >> 1;
                end else begin
                    fb = c[w-1] ^ msg[i][7-j];
                    c  = (c << 1) & mask;
                end
                if (fb) c = c ^ poly;
            end
        end
        c = (c ^ xo) & mask;
        if (rev) begin
            for (int j = 0; j < w; j++) r[w-1-j] = c[j];
            c = r;
        end
        return c;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_results(input string req, input int n);
        check(req, crc32, ref_crc(32, 32'hEDB88320, 32'hFFFFFFFF, 32'hFFFFFFFF, 1, 0, n));
        check(req, {24'd0, crc8}, ref_crc(8, 32'h07, 32'h00, 32'h00, 0, 0, n));
        check(req, {24'd0, crcrv}, ref_crc(8, 32'h07, 32'hFF, 32'h0F, 0, 1, n));
    endtask

    task automatic do_start();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R2 ready after start", {31'd0, rdy32}, 32'd1);
        check("R2 done cleared", {31'd0, dn32}, 32'd0);
    endtask

    task automatic wait_ready();
        int guard = 0;
        while (!rdy32 && guard < 50) begin
            @(negedge clk);
            guard++;
        end
    endtask

    // R3 R8 R9: drive n bytes from msg, close by last flag or by close_i
    task automatic send_msg(input int n, input bit by_close);
        for (int i = 0; i < n; i++) begin
            bit lst = (i == n - 1) && !by_close;
            wait_ready();
            in_valid_i = 1'b1;
            in_data_i  = msg[i];
            in_last_i  = lst;
            @(negedge clk);
            in_valid_i = 1'b0;
            in_last_i  = 1'b0;
            in_data_i  = $urandom;
            check("R3 ready drops on accept", {31'd0, rdy32}, 32'd0);
            for (int k = 1; k <= 8; k++) begin
                @(negedge clk);
                if (k < 8) begin
                    check("R3 busy window", {30'd0, rdy8, dn32}, 32'd0);
                end else if (lst) begin
                    check("R8 done after 8th shift", {29'd0, dn32, dn8, dnrv}, 32'd7);
                    check_results("R4 R5 R6 R7 result", n);
                end else begin
                    check("R3 ready returns", {31'd0, rdyrv}, 32'd1);
                end
            end
        end
        if (by_close) begin
            wait_ready();
            close_i = 1'b1;
            @(negedge clk);
            close_i = 1'b0;
            check("R8 done after close", {31'd0, dn32}, 32'd1);
            check_results(n == 0 ? "R10 empty message" : "R6 close result", n);
        end
        // R9: strobe ends, result frozen, bytes ignored
        in_valid_i = 1'b1;
        in_data_i  = 8'hA5;
        @(negedge clk);
        check("R8 done single cycle", {31'd0, dn32}, 32'd0);
        @(negedge clk);
        in_valid_i = 1'b0;
        check("R9 ready low in hold", {31'd0, rdy32}, 32'd0);
        check_results("R9 result held", n);
    endtask

    task automatic load_check_string();
        string s = "123456789";
        for (int i = 0; i < 9; i++) msg[i] = s[i];
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd4242));
        #(CLK_PERIOD * 2.5);
        check("R1 reset state", {30'd0, rdy32, dn32}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {28'd0, rdy8, dn8, rdyrv, dnrv}, 32'd0);

        // R11 known check values
        load_check_string();
        do_start();
        send_msg(9, 0);
        check("R11 crc32 check value", crc32, 32'hCBF43926);
        check("R11 crc8 check value", {24'd0, crc8}, 32'h000000F4);

        // R10 empty message
        do_start();
        send_msg(0, 1);
        check("R10 empty crc32", crc32, 32'h00000000);

        // R2: start in the middle of a byte aborts it
        msg[0] = 8'h3C;
        do_start();
        wait_ready();
        in_valid_i = 1'b1;
        in_data_i  = 8'hFF;
        @(negedge clk);
        in_valid_i = 1'b0;
        repeat (3) @(negedge clk);
        do_start();
        send_msg(1, 0);

        // single byte closed by close pulse
        msg[0] = 8'h80;
        do_start();
        send_msg(1, 1);

        // random messages
        for (int t = 0; t < 40; t++) begin
            int n = 1 + ($urandom % 20);
            for (int i = 0; i < n; i++) msg[i] = 8'($urandom);
            do_start();
            send_msg(n, ($urandom % 4) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule